// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. A programmable prescaler derives a slow converter clock from the system clock. A software start request then launches one conversion. The block latches the channel/reference selection, pulses a sample-and-hold strobe and walks a binary search over a DAC code, one bit per converter cycle. It reads back a comparator decision for each bit. At the end it stores the 10-bit result, raises a one-clock completion pulse and drops its busy indication.

The first conversion after the enable input rises is the long kind: 25 converter cycles, with the sample strobe late, so that the analog circuitry can settle. Every later conversion takes 13 converter cycles. Dropping enable resets the prescaler, abandons any conversion in progress and re-arms the long kind. The DAC, the comparator, the gain stage and the input multiplexer are outside this block.

The result leaves the block as a data word qualified by `done`. Conversions cannot stall, so there is no ready signal and no back-pressure. `result` holds its value until the next completion, and a consumer must capture it within one conversion time.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Prescaler code `div_sel` = n (1..7) makes one converter cycle last 2^n system clocks. Code 0 behaves as code 1 (2 clocks).
- R2: While `en` is low the prescaler is held at zero. The first converter edge comes 2^n system clocks after `en` rises. A start pulse given together with the rise of `en` therefore completes (25+1)*2^n clocks later.
- R3: A one-clock `start` pulse with `en` high and `busy` low sets `busy` on the next clock. `busy` stays high for the whole conversion. `start` is ignored while `en` is low or while `busy` is high.
- R4: The conversion begins on the first converter edge after `busy` is set. The first conversion after `en` rises lasts 25 converter cycles.
- R5: Later conversions last 13 converter cycles. `sh_strobe` pulses for one clock at the converter edge that ends cycle 1, or cycle 14 for the long kind. It therefore comes 12 converter cycles (normal) or 11 converter cycles (long) before `done`.
- R6: The bits are decided from bit 9 down to bit 0, one per converter cycle, starting right after the strobe. At the strobe, `dac_code` equals 10'h200. A trial bit is kept when `cmp_hi` is 1, meaning the input is at or above `dac_code`. The result equals the input level of an ideal comparator.
- R7: At completion `result` is written, `done` pulses high for one clock, and `busy` falls on that same clock edge. `result` then holds until the next completion.
- R8: `sel_lat` captures `sel_in` at conversion start. Changes to `sel_in` during a conversion appear only in the next conversion.
- R9: Dropping `en` during a conversion clears `busy` without a `done` pulse and leaves `result` unchanged. The next conversion is again the 25-cycle kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low resets prescaler and aborts |
| start | input | 1 | One-clock software start request |
| div_sel | input | 3 | Prescaler code (divide by 2^n, 0 acts as 1) |
| sel_in | input | 3 | Channel/reference selection code |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| busy | output | 1 | Conversion requested or running |
| sel_lat | output | 3 | Selection latched for the current conversion |
| sh_strobe | output | 1 | One-clock sample-and-hold pulse |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-clock completion pulse qualifying `result` |

## Verification
Two functions can meet in the same clock: a fresh start request and a selection change can both land on the clock of the sample strobe of a running conversion. The bench drives both at once on the strobe clock. It then checks that `sel_lat` keeps the value captured at conversion start through to `done`, and that no second conversion follows. A separate case drops `en` exactly on the strobe clock, so that the abort coincides with loading the first trial bit. The bench then checks that no `done` appears, that `result` keeps its old value, and that the next conversion takes the long timing.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DEF_RES_W    = 10;
  localparam int DEF_DIV_W    = 3;
  localparam int DEF_SEL_W    = 3;
  localparam int DEF_NORM_CYC = 13;
  localparam int DEF_INIT_CYC = 25;
  localparam int DEF_NORM_SH  = 1;
  localparam int DEF_INIT_SH  = 14;

  // effective divide exponent: code 0 is treated as code 1
  function automatic int div_shift(input int code);
    return (code == 0) ? 1 : code;
  endfunction
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int DIV_W = sar_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] cnt;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (i < sar_pkg::div_shift(int'(div_sel))) mask[i] = 1'b1;
    end
  end

  assign tick = en && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R2: disabled prescaler sits at zero
  a_r2_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R1: divide factor is at least two, so edges never abut
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int SEL_W    = sar_pkg::DEF_SEL_W,
  parameter int NORM_CYC = sar_pkg::DEF_NORM_CYC,
  parameter int INIT_CYC = sar_pkg::DEF_INIT_CYC,
  parameter int NORM_SH  = sar_pkg::DEF_NORM_SH,
  parameter int INIT_SH  = sar_pkg::DEF_INIT_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_in,
  output logic             busy,
  output logic [SEL_W-1:0] sel_lat,
  output logic             sh_strobe,
  output logic             done,
  output logic             load,
  output logic             step,
  output logic             fin
);
  localparam int CW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] N_LEN = CW'(NORM_CYC);
  localparam logic [CW-1:0] I_LEN = CW'(INIT_CYC);
  localparam logic [CW-1:0] N_SH  = CW'(NORM_SH);
  localparam logic [CW-1:0] I_SH  = CW'(INIT_SH);

  logic          running;
  logic          first;
  logic [CW-1:0] cyc;
  logic [CW-1:0] len_now;
  logic [CW-1:0] sh_now;

  assign len_now = first ? I_LEN : N_LEN;
  assign sh_now  = first ? I_SH  : N_SH;
  assign step    = en && tick && running;
  assign load    = step && (cyc == sh_now);
  assign fin     = step && (cyc == len_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      running   <= 1'b0;
      first     <= 1'b1;
      cyc       <= '0;
      sel_lat   <= '0;
      sh_strobe <= 1'b0;
      done      <= 1'b0;
    end else if (!en) begin
      busy      <= 1'b0;
      running   <= 1'b0;
      first     <= 1'b1;
      cyc       <= '0;
      sh_strobe <= 1'b0;
      done      <= 1'b0;
    end else begin
      sh_strobe <= 1'b0;
      done      <= 1'b0;
      if (start && !busy) busy <= 1'b1;
      if (tick) begin
        if (running) begin
          if (cyc == len_now) begin
            running <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            first   <= 1'b0;
          end else begin
            cyc <= cyc + 1'b1;
          end
          if (cyc == sh_now) sh_strobe <= 1'b1;
        end else if (busy) begin
          running <= 1'b1;
          cyc     <= CW'(1);
          sel_lat <= sel_in;
        end
      end
    end
  end

  // R7: completion coincides with busy falling
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R3: busy only falls at completion or on disable
  a_r3_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !busy && $past(en)) |-> done);
  // R5: strobe only inside a conversion
  a_r5_strobe_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> busy);
  // R8: latched selection frozen while running
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(sel_lat));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = sar_pkg::DEF_RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             step,
  input  logic             fin,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar;
  logic [RES_W-1:0] probe;

  assign dac_code = sar | probe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar    <= '0;
      probe  <= '0;
      result <= '0;
    end else if (!en) begin
      probe  <= '0;
    end else begin
      if (fin) result <= sar;
      if (load) begin
        sar   <= '0;
        probe <= TOP_BIT;
      end else if (step && (probe != '0)) begin
        if (cmp_hi) sar <= sar | probe;
        probe <= probe >> 1;
      end
    end
  end

  // R6: at most one trial bit at a time
  a_r6_probe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe));
  // R6: a high comparator keeps the trial bit
  a_r6_keep_bit: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (step && !load && (probe != '0) && cmp_hi) |=> ((sar & $past(probe)) != '0));
  // R7: result only moves at completion
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin) |-> $stable(result));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W    = sar_pkg::DEF_RES_W,
  parameter int DIV_W    = sar_pkg::DEF_DIV_W,
  parameter int SEL_W    = sar_pkg::DEF_SEL_W,
  parameter int NORM_CYC = sar_pkg::DEF_NORM_CYC,
  parameter int INIT_CYC = sar_pkg::DEF_INIT_CYC,
  parameter int NORM_SH  = sar_pkg::DEF_NORM_SH,
  parameter int INIT_SH  = sar_pkg::DEF_INIT_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             cmp_hi,
  output logic             busy,
  output logic [SEL_W-1:0] sel_lat,
  output logic             sh_strobe,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done
);
  logic tick, load, step, fin;

  sar_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .tick(tick)
  );

  sar_sequencer #(
    .SEL_W(SEL_W), .NORM_CYC(NORM_CYC), .INIT_CYC(INIT_CYC),
    .NORM_SH(NORM_SH), .INIT_SH(INIT_SH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .start(start),
    .sel_in(sel_in), .busy(busy), .sel_lat(sel_lat), .sh_strobe(sh_strobe),
    .done(done), .load(load), .step(step), .fin(fin)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .step(step), .fin(fin),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .result(result)
  );

  // R9: no completion while disabled
  a_r9_no_done_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !done);
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [2:0] sel_in = 3'd0;
  logic [9:0] vin = 10'd0;
  logic       cmp_hi;
  logic       busy, sh_strobe, done;
  logic [2:0] sel_lat;
  logic [9:0] dac_code, result;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator stub
  assign cmp_hi = (vin >= dac_code);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .div_sel(div_sel),
    .sel_in(sel_in), .cmp_hi(cmp_hi), .busy(busy), .sel_lat(sel_lat),
    .sh_strobe(sh_strobe), .dac_code(dac_code), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int per(input int code);
    return 1 << ((code == 0) ? 1 : code);
  endfunction

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one conversion; with_en raises en together with start
  task automatic run_conv(input bit exp_first, input bit with_en, input [9:0] v,
                          input int new_sel, input bit restart, input int exp_sel);
    int n = 0;
    int s_at = -1;
    int p = per(int'(div_sel));
    vin = v;
    if (with_en) begin
      en = 1'b0;
      idle_clocks(3);
    end
    @(negedge clk);
    if (with_en) en = 1'b1;
    start = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (n == 1) chk(busy == 1'b1, "R3", "busy after start", busy, 1);
      if (sh_strobe) begin
        s_at = n;
        chk(dac_code == 10'h200, "R6", "dac at strobe", dac_code, 10'h200);
        chk(busy == 1'b1, "R3", "busy mid conversion", busy, 1);
        if (new_sel >= 0) sel_in = 3'(new_sel);
        if (restart) start = 1'b1;
      end
      if (done || n > 40000) break;
    end
    chk(done == 1'b1, "R7", "done seen", done, 1);
    chk(busy == 1'b0, "R7", "busy low at done", busy, 0);
    chk(result == v, "R6", "result", result, v);
    chk(sel_lat == 3'(exp_sel), "R8", "latched selection", sel_lat, exp_sel);
    if (exp_first)
      chk(n - s_at == 11 * p, "R4", "long strobe-to-done", n - s_at, 11 * p);
    else
      chk(n - s_at == 12 * p, "R5", "normal strobe-to-done", n - s_at, 12 * p);
    if (with_en)
      chk(n == 26 * p, "R2", "enable-to-done clocks", n, 26 * p);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one clock", done, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R3", "reset busy", busy, 0);
    chk(done == 1'b0, "R7", "reset done", done, 0);
    chk(result == 10'd0, "R7", "reset result", result, 0);
    chk(dac_code == 10'd0, "R6", "reset dac", dac_code, 0);
  endtask

  task automatic t_ignored_starts();
    int seen = 0;
    en = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle_clocks(3);
    chk(busy == 1'b0, "R3", "start ignored while disabled", busy, 0);
    // restart during busy must not yield a second conversion
    div_sel = 3'd2;
    run_conv(1'b1, 1'b1, 10'h0F0, -1, 1'b1, sel_in);
    for (int i = 0; i < 30 * per(2); i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(seen == 0, "R3", "start while busy ignored", seen, 0);
    chk(busy == 1'b0, "R3", "idle after ignored start", busy, 0);
  endtask

  task automatic t_abort();
    logic [9:0] keep;
    int seen = 0;
    div_sel = 3'd2;
    run_conv(1'b0, 1'b0, 10'h13C, -1, 1'b0, sel_in);
    keep = result;
    vin = 10'h3C3;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sh_strobe) break;
    end
    en = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(seen == 0, "R9", "no done after abort", seen, 0);
    chk(busy == 1'b0, "R9", "busy cleared by abort", busy, 0);
    chk(result == keep, "R9", "result kept on abort", result, keep);
    run_conv(1'b1, 1'b1, 10'h3C3, -1, 1'b0, sel_in);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_clocks(3);
    t_reset();
    rst_n = 1'b1;
    idle_clocks(2);
    // R1: code 0 and code 1 both divide by two
    div_sel = 3'd0; sel_in = 3'd1;
    run_conv(1'b1, 1'b1, 10'h155, -1, 1'b0, 1);
    run_conv(1'b0, 1'b0, 10'h2AA, -1, 1'b0, 1);
    run_conv(1'b0, 1'b0, 10'h3FF, -1, 1'b0, 1);
    run_conv(1'b0, 1'b0, 10'h000, -1, 1'b0, 1);
    div_sel = 3'd1;
    run_conv(1'b1, 1'b1, 10'h201, -1, 1'b0, 1);
    // R8: selection change and restart on the strobe clock
    div_sel = 3'd3; sel_in = 3'd5;
    run_conv(1'b1, 1'b1, 10'h200, -1, 1'b0, 5);
    run_conv(1'b0, 1'b0, 10'h1FF, 2, 1'b1, 5);
    run_conv(1'b0, 1'b0, 10'h0F0, -1, 1'b0, 2);
    div_sel = 3'd7;
    run_conv(1'b1, 1'b1, 10'h3A5, -1, 1'b0, 2);
    run_conv(1'b0, 1'b0, 10'h05A, -1, 1'b0, 2);
    t_ignored_starts();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule